// File: doc/BRIEF.md
# Write-Back Cache Snoop Responder

This block answers address probes from an external bus master for a small write-back cache. While the master owns the bus, the block checks whether the probed line is cached and whether it is dirty. It drives two active-low results after a fixed latency. A dirty hit makes the block take the bus back and copy the line out to memory as a four-beat burst. Probes arriving in the meantime are ignored.

The master asks for the bus on `bus_req`. The block grants it on `bus_grant` one clock later. A probe is a one-cycle pulse on `snp_strobe` with an address and a kill qualifier. A kill value of 0 marks a probe caused by a read. A kill value of 1 marks a probe caused by a write, and the line is then dropped. A processor-side port fills lines into the tag store, but only while the bus is not granted and no probe or write-back is in progress.

The controller is a five-state machine:
- `ST_IDLE` goes to `ST_LOOK` when a probe is accepted.
- `ST_LOOK` goes to `ST_ANSWER` after reading the tag store.
- `ST_ANSWER` goes to `ST_WAIT_REL` on a dirty hit and returns to `ST_IDLE` otherwise.
- `ST_WAIT_REL` goes to `ST_WRITEBACK` once `bus_req` is sampled low.
- `ST_WRITEBACK` returns to `ST_IDLE` when memory accepts the last beat.

Top module: `snp_wb_ctrl`

## Requirements
- R1: After reset, `bus_grant`=0, `mod_hit_n`=1, `line_hit_n`=1, `mem_wr_valid`=0 and `cpu_wr_ready`=1. Outside a write-back, `bus_grant` takes the value of `bus_req` sampled at the previous rising edge. During a write-back, `bus_grant` is held at 0.
- R2: A probe pulse is accepted only if `bus_grant` is 1 at the sampling edge and the controller is in `ST_IDLE`. Any other pulse changes no output and no tag state.
- R3: `mod_hit_n` stays 1 through the two clocks after the accepting edge. It is updated at the second rising edge after acceptance: 0 if the probed line is valid, its tag matches and it is modified, and 1 otherwise.
- R4: The tag store holds 16 direct-mapped lines of 16 bytes. Address bits [7:4] select the line and bits [31:8] form the tag. A probe to the same index with a different tag is a miss.
- R5: A write-back is four beats of 32-bit words. The beat addresses are the line base plus 0, 4, 8 and 12, in that order, with `mem_wr_beat` equal to 0..3. The first beat is always offset 0, whatever the low bits of the probe address. A beat is held stable until `mem_ready` is sampled high.
- R6: `mem_wr_valid` first rises in the cycle after the edge at which `bus_req` is sampled low in `ST_WAIT_REL`. It stays 0 while `bus_req` remains high.
- R7: From a dirty hit until the write-back ends, further probe pulses are ignored and `mod_hit_n` stays 0.
- R8: `mod_hit_n` and `line_hit_n` return to 1 at the edge where memory accepts the fourth beat.
- R9: `line_hit_n` is updated with the same timing as `mod_hit_n` and is 0 when the probed line is present. A kill=1 hit invalidates the line, after the write-back if one is needed. A kill=0 hit keeps the line valid, and clears its modified bit once the write-back completes.
- R10: `cpu_wr_ready` is 1 only when `bus_grant` is 0 and the controller is in `ST_IDLE`. When `cpu_wr_en` is high while ready, the line is filled with the address tag, marked valid, and marked modified if `cpu_wr_dirty` is 1. A request made while not ready is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | External master requests the bus |
| bus_grant | output | 1 | Bus handed to the external master |
| snp_strobe | input | 1 | Probe strobe, one cycle |
| snp_kill | input | 1 | Probe qualifier: 0 read-caused, 1 write-caused (invalidate) |
| snp_addr | input | 32 | Probe address |
| line_hit_n | output | 1 | Active-low: probed line present |
| mod_hit_n | output | 1 | Active-low: probed line present and modified |
| cpu_wr_en | input | 1 | Processor fill request |
| cpu_wr_addr | input | 32 | Processor fill address |
| cpu_wr_dirty | input | 1 | Mark the filled line modified |
| cpu_wr_ready | output | 1 | Fill port open |
| mem_wr_valid | output | 1 | Write-back beat valid |
| mem_wr_addr | output | 32 | Write-back beat address |
| mem_wr_beat | output | 2 | Write-back beat index |
| mem_ready | input | 1 | Memory accepts the current beat |

## Verification
The bench probes while the bus has not been granted and checks that nothing answers. It holds `bus_req` high after a dirty hit and fires extra probes, so a design that starts the burst early or re-samples probes would put a beat on the bus or raise `mod_hit_n`. Random `mem_ready` stalls expose a beat counter that advances without a handshake, or that starts at the probe's own offset. Repeat probes after kill and read hits expose wrong invalidation or a modified bit left set. A probe to the same index with a different tag exposes an index-only compare.

// File: rtl/snp_pkg.sv
package snp_pkg;
    localparam int ADDR_W     = 32;
    localparam int LINES      = 16;
    localparam int LINE_BYTES = 16;
    localparam int WORD_BYTES = 4;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(LINES);
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
    localparam int BEATS      = LINE_BYTES / WORD_BYTES;
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int WB_W       = $clog2(WORD_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_ANSWER,
        ST_WAIT_REL,
        ST_WRITEBACK
    } snp_state_e;
endpackage

// File: rtl/snp_tag_store.sv
module snp_tag_store
    import snp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_dirty,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_clr_valid,
    input  logic              upd_clr_dirty
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] fill_idx;

    assign lk_idx   = lk_addr[OFF_W +: IDX_W];
    assign fill_idx = fill_addr[OFF_W +: IDX_W];

    // Lookup: the tag must match as well as the index
    assign lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_addr[ADDR_W-1 -: TAG_W]);
    assign lk_dirty = dirty_q[lk_idx];

    // Probe-side updates take priority over fills
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (upd_en) begin
            if (upd_clr_valid) valid_q[upd_idx] <= 1'b0;
            if (upd_clr_dirty) dirty_q[upd_idx] <= 1'b0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
            dirty_q[fill_idx] <= fill_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !upd_en) begin
            tag_q[fill_idx] <= fill_addr[ADDR_W-1 -: TAG_W];
        end
    end
endmodule

// File: rtl/snp_bus_handover.sv
module snp_bus_handover (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req,
    input  logic wb_busy,
    output logic bus_grant
);
    // Grant follows the request by one clock, withheld while we own the bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_grant <= 1'b0;
        else        bus_grant <= bus_req && !wb_busy;
    end
endmodule

// File: rtl/snp_wb_burst.sv
module snp_wb_burst
    import snp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              mem_ready,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [BEAT_W-1:0] mem_wr_beat,
    output logic              last_done
);
    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                beat_q <= '0;
        else if (!active)          beat_q <= '0;
        else if (mem_ready)        beat_q <= beat_q + 1'b1;
    end

    assign mem_wr_valid = active;
    assign mem_wr_beat  = beat_q;
    assign mem_wr_addr  = {base_addr[ADDR_W-1:OFF_W], beat_q, {WB_W{1'b0}}};
    assign last_done    = active && mem_ready && (beat_q == BEAT_W'(BEATS-1));
endmodule

// File: rtl/snp_wb_ctrl.sv
module snp_wb_ctrl
    import snp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    output logic              bus_grant,
    input  logic              snp_strobe,
    input  logic              snp_kill,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              line_hit_n,
    output logic              mod_hit_n,
    input  logic              cpu_wr_en,
    input  logic [ADDR_W-1:0] cpu_wr_addr,
    input  logic              cpu_wr_dirty,
    output logic              cpu_wr_ready,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [BEAT_W-1:0] mem_wr_beat,
    input  logic              mem_ready
);
    snp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] snp_addr_q;
    logic              snp_kill_q;
    logic              look_hit_q;
    logic              look_mod_q;
    logic              lk_hit, lk_dirty;
    logic              accept, wb_active, wb_last;
    logic              upd_en, fill_en;

    assign accept       = (state_q == ST_IDLE) && snp_strobe && bus_grant;
    assign wb_active    = (state_q == ST_WRITEBACK);
    assign cpu_wr_ready = !bus_grant && (state_q == ST_IDLE);
    assign fill_en      = cpu_wr_en && cpu_wr_ready;

    // Clean kill hit is dropped at answer time; dirty lines after the last beat
    assign upd_en = ((state_q == ST_ANSWER) && look_hit_q && !look_mod_q && snp_kill_q)
                  || wb_last;

    snp_tag_store u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_addr      (snp_addr_q),
        .lk_hit       (lk_hit),
        .lk_dirty     (lk_dirty),
        .fill_en      (fill_en),
        .fill_addr    (cpu_wr_addr),
        .fill_dirty   (cpu_wr_dirty),
        .upd_en       (upd_en),
        .upd_idx      (snp_addr_q[OFF_W +: IDX_W]),
        .upd_clr_valid(snp_kill_q),
        .upd_clr_dirty(1'b1)
    );

    snp_bus_handover u_handover (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .wb_busy  (wb_active),
        .bus_grant(bus_grant)
    );

    snp_wb_burst u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (wb_active),
        .base_addr   (snp_addr_q),
        .mem_ready   (mem_ready),
        .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_beat (mem_wr_beat),
        .last_done   (wb_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = ST_LOOK;
            ST_LOOK:      state_d = ST_ANSWER;
            ST_ANSWER:    state_d = look_mod_q ? ST_WAIT_REL : ST_IDLE;
            ST_WAIT_REL:  if (!bus_req) state_d = ST_WRITEBACK;
            ST_WRITEBACK: if (wb_last) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register with probe capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            snp_addr_q <= '0;
            snp_kill_q <= 1'b0;
            look_hit_q <= 1'b0;
            look_mod_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                snp_addr_q <= snp_addr;
                snp_kill_q <= snp_kill;
            end
            if (state_q == ST_LOOK) begin
                look_hit_q <= lk_hit;
                look_mod_q <= lk_hit && lk_dirty;
            end
        end
    end

    // Registered responses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_hit_n  <= 1'b1;
            line_hit_n <= 1'b1;
        end else if (state_q == ST_ANSWER) begin
            mod_hit_n  <= !look_mod_q;
            line_hit_n <= !look_hit_q;
        end else if (wb_last) begin
            mod_hit_n  <= 1'b1;
            line_hit_n <= 1'b1;
        end
    end
endmodule

// File: rtl/snp_wb_checker.sv
module snp_wb_checker
    import snp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_grant,
    input logic              mod_hit_n,
    input logic              cpu_wr_ready,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              mem_ready
);
    p_grant_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> $past(bus_req));

    p_no_grant_in_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> !bus_grant);

    p_first_beat_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> (mem_wr_addr[OFF_W-1:WB_W] == '0));

    p_stall_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_ready) |=> (mem_wr_valid && $stable(mem_wr_addr)));

    p_wb_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> !$past(bus_req));

    p_mod_low_in_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> !mod_hit_n);

    p_release_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_hit_n) |-> $past(mem_wr_valid && mem_ready));

    p_fill_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> !cpu_wr_ready);
endmodule

bind snp_wb_ctrl snp_wb_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_grant   (bus_grant),
    .mod_hit_n   (mod_hit_n),
    .cpu_wr_ready(cpu_wr_ready),
    .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr (mem_wr_addr),
    .mem_ready   (mem_ready)
);

// File: tb/snp_wb_ctrl_test.sv
module snp_wb_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_grant;
    logic        snp_strobe = 1'b0;
    logic        snp_kill = 1'b0;
    logic [31:0] snp_addr = '0;
    logic        line_hit_n, mod_hit_n;
    logic        cpu_wr_en = 1'b0;
    logic [31:0] cpu_wr_addr = '0;
    logic        cpu_wr_dirty = 1'b0;
    logic        cpu_wr_ready;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_addr;
    logic [1:0]  mem_wr_beat;
    logic        mem_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit g = 0;

    logic [23:0] m_tag [16];
    bit          m_val [16];
    bit          m_dir [16];

    always #5 clk = ~clk;

    snp_wb_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_grant(bus_grant),
        .snp_strobe(snp_strobe), .snp_kill(snp_kill), .snp_addr(snp_addr),
        .line_hit_n(line_hit_n), .mod_hit_n(mod_hit_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_dirty(cpu_wr_dirty),
        .cpu_wr_ready(cpu_wr_ready), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_beat(mem_wr_beat), .mem_ready(mem_ready)
    );

    function automatic bit f_hit(input logic [31:0] a);
        return m_val[a[7:4]] && (m_tag[a[7:4]] == a[31:8]);
    endfunction

    function automatic bit f_mod(input logic [31:0] a);
        return f_hit(a) && m_dir[a[7:4]];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [31:0] a, input bit d);
        cpu_wr_en = 1'b1; cpu_wr_addr = a; cpu_wr_dirty = d;
        chk("R10 fill ready", 32'(cpu_wr_ready), 32'(!g));
        @(posedge clk);
        if (!g) begin
            m_tag[a[7:4]] = a[31:8]; m_val[a[7:4]] = 1; m_dir[a[7:4]] = d;
        end
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic grant();
        bus_req = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 grant rise", 32'(bus_grant), 32'd1);
        chk("R10 blocked on grant", 32'(cpu_wr_ready), 32'd0);
        g = 1;
    endtask

    task automatic release_bus();
        bus_req = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 grant fall", 32'(bus_grant), 32'd0);
        g = 0;
    endtask

    task automatic ignored_probe(input logic [31:0] a);
        logic prev_hit;
        prev_hit = line_hit_n;
        snp_strobe = 1'b1; snp_addr = a; snp_kill = 1'b1;
        @(posedge clk); @(negedge clk);
        snp_strobe = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 ignored mod_hit_n", 32'(mod_hit_n), 32'd1);
        chk("R2 ignored line_hit_n", 32'(line_hit_n), 32'(prev_hit));
        chk("R2 ignored no burst", 32'(mem_wr_valid), 32'd0);
    endtask

    task automatic snoop(input logic [31:0] a, input bit k);
        bit eh, em;
        int b;
        eh = f_hit(a); em = f_mod(a);
        snp_strobe = 1'b1; snp_addr = a; snp_kill = k;
        @(posedge clk); @(negedge clk);
        snp_strobe = 1'b0;
        chk("R3 latency 1", 32'(mod_hit_n), 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R3 latency 2", 32'(mod_hit_n), 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R3 mod_hit_n", 32'(mod_hit_n), 32'(!em));
        chk("R9 line_hit_n", 32'(line_hit_n), 32'(!eh));
        if (!em) begin
            if (eh && k) m_val[a[7:4]] = 0;
            return;
        end
        // Held bus: extra probes must be ignored and no beat may appear
        for (int i = 0; i < int'($urandom % 4); i++) begin
            snp_strobe = 1'b1; snp_addr = {$urandom} ; snp_kill = 1'b1;
            @(posedge clk); @(negedge clk);
            snp_strobe = 1'b0;
            chk("R7 still low", 32'(mod_hit_n), 32'd0);
            chk("R6 no burst under request", 32'(mem_wr_valid), 32'd0);
        end
        snp_strobe = 1'b0;
        bus_req = 1'b0;
        @(posedge clk); @(negedge clk);
        g = 0;
        chk("R1 grant low in burst", 32'(bus_grant), 32'd0);
        b = 0;
        while (b < 4) begin
            mem_ready = ($urandom % 3) != 0;
            chk("R5 beat valid", 32'(mem_wr_valid), 32'd1);
            chk("R5 beat addr", mem_wr_addr, {a[31:4], 2'(b), 2'b00});
            chk("R5 beat index", 32'(mem_wr_beat), 32'(b));
            chk("R8 low during burst", 32'(mod_hit_n), 32'd0);
            chk("R10 blocked in burst", 32'(cpu_wr_ready), 32'd0);
            @(posedge clk); @(negedge clk);
            if (mem_ready) b++;
        end
        mem_ready = 1'b0;
        chk("R8 mod_hit_n released", 32'(mod_hit_n), 32'd1);
        chk("R8 line_hit_n released", 32'(line_hit_n), 32'd1);
        chk("R5 burst ended", 32'(mem_wr_valid), 32'd0);
        if (k) m_val[a[7:4]] = 0;
        m_dir[a[7:4]] = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin m_val[i] = 0; m_dir[i] = 0; m_tag[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset grant", 32'(bus_grant), 32'd0);
        chk("R1 reset mod_hit_n", 32'(mod_hit_n), 32'd1);
        chk("R1 reset line_hit_n", 32'(line_hit_n), 32'd1);
        chk("R1 reset mem_wr_valid", 32'(mem_wr_valid), 32'd0);
        chk("R1 reset cpu_wr_ready", 32'(cpu_wr_ready), 32'd1);

        fill(32'h1234_5670, 1);
        fill(32'hABCD_0120, 0);
        fill(32'h0000_00F0, 1);

        ignored_probe(32'h1234_5670);          // R2: no grant yet
        grant();
        fill(32'h5555_5530, 1);                // R10: dropped
        snoop(32'h5555_5530, 0);               // R10 check: miss
        snoop(32'h9234_5670, 0);               // R4: same index, other tag
        snoop(32'hABCD_0124, 0);               // R9: clean read hit
        snoop(32'hABCD_0128, 1);               // R9: clean kill hit
        snoop(32'hABCD_0120, 0);               // R9: now a miss
        snoop(32'h1234_567C, 0);               // R5: dirty, non-zero offset
        grant();
        snoop(32'h1234_5670, 0);               // R9: valid, now clean
        snoop(32'h0000_00F4, 1);               // dirty kill
        grant();
        snoop(32'h0000_00F0, 0);               // R9: gone
        snoop(32'h1234_5670, 0);               // R7: earlier extra probes had no effect

        for (int r = 0; r < 30; r++) begin
            release_bus();
            for (int f = 0; f < 3; f++)
                fill({22'($urandom % 3), 2'b00, 4'($urandom), 4'($urandom)}, 1'($urandom));
            grant();
            for (int s = 0; s < 3; s++) begin
                snoop({22'($urandom % 3), 2'b00, 4'($urandom), 4'($urandom)}, 1'($urandom));
                if (!g) grant();
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule